// File: doc/BRIEF.md
# Step-Down Regulator Sequencing and Protection Supervisor

This block is the digital supervisor of a synchronous step-down converter. It decides when the power stage may switch and starts the soft-start ramp. It also drives the power-good indication and latches the converter off after a sustained short circuit. Its inputs are the enable pin and a set of flags from analog comparators: input supply adequate, current limiter engaged, over-temperature, and output at or above 90 %, 75 % and 50 % of its target. All of these flags arrive asynchronously.

Every flag passes through a two-stage synchronizer before the controller uses it. A four-state controller (standby, ramping, running, tripped) turns the synchronized flags into a run enable and soft-start indications. It also keeps a sticky fault status. A separate qualifier turns the 75 %/90 % comparator pair into a hysteretic power-good with a delayed rising edge. Every timer length is a parameter counted in clock cycles, and the defaults suit a 50 MHz clock. Every output is a register.

Top module: `buck_supervisor`

## Requirements
- R1: If the enable pin is low or the input supply flag is low, then `run_en`, `ss_done`, `pwr_good` and `fault_latched` are all 0 three clock cycles later. The controller also returns to standby.
- R2: With enable high, the supply flag high and no over-temperature, `run_en` rises three cycles after the last of these conditions holds. In that same cycle `ss_start` pulses high for exactly one cycle.
- R3: `ss_done` rises exactly `SS_CYCLES` cycles after `run_en` rises. It stays low during the whole ramp.
- R4: In the running state, the 90 % flag must be seen, and the 75 % flag must then stay high. `pwr_good` rises `PG_DELAY_CYCLES` cycles after the synchronized 90 % flag, or after entry to the running state, whichever comes later.
- R5: After the 90 % flag drops, `pwr_good` stays high as long as the 75 % flag holds. It falls three cycles after the 75 % flag drops. To rise again it needs a new 90 % crossing followed by the full delay.
- R6: `pwr_good` is 0 throughout soft-start and whenever `fault_latched` is 1.
- R7: A current limit with the 50 % flag low, held for `LATCH_CYCLES` consecutive synchronized cycles during ramp or run, drops `run_en` and sets `fault_latched`. An episode one cycle shorter has no effect, and the qualification count restarts from zero afterwards.
- R8: A current limit while the 50 % flag is high never sets `fault_latched`, however long it lasts.
- R9: `fault_latched` stays set while enable and supply stay high, even after the current limit ends. Pulling enable low, or letting the supply flag drop, clears it three cycles later, and the next start goes through soft-start.
- R10: The over-temperature flag drops `run_en` three cycles after it rises. Three cycles after it clears, the converter restarts with an `ss_start` pulse and a fresh ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Enable pin, asynchronous, active high |
| vin_ok | input | 1 | Input supply above undervoltage threshold, asynchronous |
| ilim_act | input | 1 | Current limiter engaged, asynchronous |
| tsd_act | input | 1 | Over-temperature detected, asynchronous |
| vo_ge90 | input | 1 | Output at or above 90 % of target |
| vo_ge75 | input | 1 | Output at or above 75 % of target |
| vo_ge50 | input | 1 | Output at or above 50 % of target |
| run_en | output | 1 | Power stage may switch |
| ss_start | output | 1 | One-cycle pulse when a soft-start ramp begins |
| ss_done | output | 1 | Soft-start ramp complete, converter running |
| pwr_good | output | 1 | Power good; 1 releases the open-drain pin, 0 pulls it low |
| fault_latched | output | 1 | Short-circuit latch-off active |

## Verification
Each input change reaches an output register three edges after the bench drives it: two synchronizer stages, then the output register loaded from the controller's next state. A delayed result adds its own count on top of that. The ramp completes `SS_CYCLES` edges after `run_en`. Power-good rises `PG_DELAY_CYCLES` edges after the qualifying point. A latch-off lands on edge `LATCH_CYCLES + 2` of a current-limit episode. The bench drives on the falling edge and samples just after a counted rising edge. It checks the edge just before each event as well as the edge it is due, so an off-by-one in any counter or stage shows up as a mismatch.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_ON   = 2'd2,
    ST_TRIP = 2'd3
  } sup_state_e;

  localparam int unsigned FLAG_W = 7;
  localparam int unsigned F_EN   = 6;
  localparam int unsigned F_VIN  = 5;
  localparam int unsigned F_ILIM = 4;
  localparam int unsigned F_TSD  = 3;
  localparam int unsigned F_G90  = 2;
  localparam int unsigned F_G75  = 1;
  localparam int unsigned F_G50  = 0;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sup_timer.sv
module sup_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  // Counts consecutive cycles of run; any gap restarts from zero.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == LAST);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/sup_pgood.sv
module sup_pgood #(
  parameter int unsigned DELAY = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hi_ok,
  input  logic lo_ok,
  output logic pg
);
  logic armed;
  logic armed_nxt;
  logic dly_exp;

  // Hysteresis: arm on the upper flag, disarm only when the lower one drops.
  assign armed_nxt = enable && lo_ok && (armed || hi_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      pg    <= 1'b0;
    end else begin
      armed <= armed_nxt;
      pg    <= armed_nxt && (pg || dly_exp);
    end
  end

  sup_timer #(.LIMIT(DELAY)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .run    (armed),
    .expire (dly_exp)
  );

  p_pg_drop_r5: assert property (@(posedge clk) disable iff (rst)
    !lo_ok |=> !pg);
  p_pg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pg && enable && lo_ok) |=> pg);
  p_pg_off_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pg);
endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned SS_CYCLES       = 50000,
  parameter int unsigned LATCH_CYCLES    = 100000,
  parameter int unsigned PG_DELAY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_pin,
  input  logic vin_ok,
  input  logic ilim_act,
  input  logic tsd_act,
  input  logic vo_ge90,
  input  logic vo_ge75,
  input  logic vo_ge50,
  output logic run_en,
  output logic ss_start,
  output logic ss_done,
  output logic pwr_good,
  output logic fault_latched
);
  logic [FLAG_W-1:0] raw_flags;
  logic [FLAG_W-1:0] flags;
  logic active;
  logic ss_run, ss_exp;
  logic trip_run, trip_exp;
  logic on_nxt;
  sup_state_e state, state_nxt;

  assign raw_flags[F_EN]   = en_pin;
  assign raw_flags[F_VIN]  = vin_ok;
  assign raw_flags[F_ILIM] = ilim_act;
  assign raw_flags[F_TSD]  = tsd_act;
  assign raw_flags[F_G90]  = vo_ge90;
  assign raw_flags[F_G75]  = vo_ge75;
  assign raw_flags[F_G50]  = vo_ge50;

  sup_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (flags)
  );

  assign active   = flags[F_EN] && flags[F_VIN];
  assign ss_run   = (state == ST_RAMP);
  assign trip_run = ((state == ST_RAMP) || (state == ST_ON)) &&
                    flags[F_ILIM] && !flags[F_G50];

  sup_timer #(.LIMIT(SS_CYCLES)) u_ss (
    .clk    (clk),
    .rst    (rst),
    .run    (ss_run),
    .expire (ss_exp)
  );

  sup_timer #(.LIMIT(LATCH_CYCLES)) u_trip (
    .clk    (clk),
    .rst    (rst),
    .run    (trip_run),
    .expire (trip_exp)
  );

  // Losing enable or supply always wins; that is also how the trip clears.
  always_comb begin
    state_nxt = state;
    if (!active) begin
      state_nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (!flags[F_TSD]) state_nxt = ST_RAMP;
        ST_RAMP: begin
          if (flags[F_TSD])  state_nxt = ST_IDLE;
          else if (trip_exp) state_nxt = ST_TRIP;
          else if (ss_exp)   state_nxt = ST_ON;
        end
        ST_ON: begin
          if (flags[F_TSD])  state_nxt = ST_IDLE;
          else if (trip_exp) state_nxt = ST_TRIP;
        end
        ST_TRIP: state_nxt = ST_TRIP;
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  assign on_nxt = (state_nxt == ST_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      run_en        <= 1'b0;
      ss_start      <= 1'b0;
      ss_done       <= 1'b0;
      fault_latched <= 1'b0;
    end else begin
      state         <= state_nxt;
      run_en        <= (state_nxt == ST_RAMP) || on_nxt;
      ss_start      <= (state_nxt == ST_RAMP) && (state != ST_RAMP);
      ss_done       <= on_nxt;
      fault_latched <= (state_nxt == ST_TRIP);
    end
  end

  sup_pgood #(.DELAY(PG_DELAY_CYCLES)) u_pg (
    .clk    (clk),
    .rst    (rst),
    .enable (on_nxt),
    .hi_ok  (flags[F_G90]),
    .lo_ok  (flags[F_G75]),
    .pg     (pwr_good)
  );

  p_standby_r1: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!run_en && !ss_done && !fault_latched));
  p_ss_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ss_start |=> !ss_start);
  p_run_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> ss_start);
  p_ramp_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_done) |-> $past(run_en));
  p_pg_fault_r6: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> !pwr_good);
  p_trip_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && active) |=> fault_latched);
  p_tsd_off_r10: assert property (@(posedge clk) disable iff (rst)
    flags[F_TSD] |=> !run_en);
endmodule

// File: tb/buck_supervisor_tb.sv
module buck_supervisor_tb;
  localparam int SS  = 40;
  localparam int LAT = 30;
  localparam int PGD = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_pin = 1'b0, vin_ok = 1'b0, ilim_act = 1'b0, tsd_act = 1'b0;
  logic vo_ge90 = 1'b0, vo_ge75 = 1'b0, vo_ge50 = 1'b0;
  logic run_en, ss_start, ss_done, pwr_good, fault_latched;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  buck_supervisor #(
    .SS_CYCLES(SS), .LATCH_CYCLES(LAT), .PG_DELAY_CYCLES(PGD)
  ) u_dut (
    .clk(clk), .rst(rst), .en_pin(en_pin), .vin_ok(vin_ok),
    .ilim_act(ilim_act), .tsd_act(tsd_act), .vo_ge90(vo_ge90),
    .vo_ge75(vo_ge75), .vo_ge50(vo_ge50), .run_en(run_en),
    .ss_start(ss_start), .ss_done(ss_done), .pwr_good(pwr_good),
    .fault_latched(fault_latched)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    edges(3);
    @(negedge clk) rst = 1'b0;
    edges(2);
    chk("R1", "run_en after reset", run_en, 1'b0);
    chk("R1", "pwr_good after reset", pwr_good, 1'b0);
    chk("R1", "fault after reset", fault_latched, 1'b0);
    chk("R1", "ss_done after reset", ss_done, 1'b0);
  endtask

  task automatic t_start_up();
    @(negedge clk);
    vo_ge90 = 1'b1; vo_ge75 = 1'b1; vo_ge50 = 1'b1;
    en_pin = 1'b1; vin_ok = 1'b1;
    edges(2);
    chk("R2", "run_en before sync", run_en, 1'b0);
    edges(1);
    chk("R2", "run_en rise", run_en, 1'b1);
    chk("R2", "ss_start pulse", ss_start, 1'b1);
    chk("R3", "ss_done at ramp start", ss_done, 1'b0);
    edges(1);
    chk("R2", "ss_start one cycle", ss_start, 1'b0);
    edges(SS - 2);
    chk("R3", "ss_done one before end", ss_done, 1'b0);
    chk("R6", "pwr_good in ramp", pwr_good, 1'b0);
    edges(1);
    chk("R3", "ss_done at end", ss_done, 1'b1);
    edges(PGD - 1);
    chk("R4", "pwr_good one before delay", pwr_good, 1'b0);
    edges(1);
    chk("R4", "pwr_good after delay", pwr_good, 1'b1);
  endtask

  task automatic t_hysteresis();
    @(negedge clk) vo_ge90 = 1'b0;
    edges(6);
    chk("R5", "pg held between 75 and 90", pwr_good, 1'b1);
    @(negedge clk) vo_ge75 = 1'b0;
    edges(2);
    chk("R5", "pg before drop lands", pwr_good, 1'b1);
    edges(1);
    chk("R5", "pg drops below 75", pwr_good, 1'b0);
    @(negedge clk) vo_ge75 = 1'b1;
    edges(10);
    chk("R5", "pg stays low without 90", pwr_good, 1'b0);
    @(negedge clk) vo_ge90 = 1'b1;
    edges(PGD + 2);
    chk("R4", "pg one before delay", pwr_good, 1'b0);
    edges(1);
    chk("R4", "pg after 90 crossing", pwr_good, 1'b1);
  endtask

  task automatic t_high_ilim();
    @(negedge clk) ilim_act = 1'b1;
    edges(LAT + 10);
    chk("R8", "no trip with output above half", fault_latched, 1'b0);
    chk("R8", "run_en kept", run_en, 1'b1);
    @(negedge clk) ilim_act = 1'b0;
    edges(3);
  endtask

  task automatic t_trip();
    @(negedge clk); ilim_act = 1'b1; vo_ge50 = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk) ilim_act = 1'b0;
    edges(6);
    chk("R7", "short episode no trip", fault_latched, 1'b0);
    chk("R7", "short episode run_en", run_en, 1'b1);
    @(negedge clk) ilim_act = 1'b1;
    edges(LAT + 1);
    chk("R7", "trip one before limit", fault_latched, 1'b0);
    edges(1);
    chk("R7", "trip at limit", fault_latched, 1'b1);
    chk("R7", "run_en off on trip", run_en, 1'b0);
    chk("R6", "pwr_good off on trip", pwr_good, 1'b0);
    @(negedge clk); ilim_act = 1'b0; vo_ge50 = 1'b1;
    edges(10);
    chk("R9", "trip sticky", fault_latched, 1'b1);
    chk("R9", "run_en stays off", run_en, 1'b0);
  endtask

  task automatic t_clear_by_enable();
    @(negedge clk) en_pin = 1'b0;
    edges(3);
    chk("R9", "enable low clears trip", fault_latched, 1'b0);
    chk("R1", "enable low run_en", run_en, 1'b0);
  endtask

  task automatic t_clear_by_supply();
    @(negedge clk) vin_ok = 1'b0;
    edges(2);
    chk("R9", "trip before supply drop lands", fault_latched, 1'b1);
    edges(1);
    chk("R9", "supply drop clears trip", fault_latched, 1'b0);
  endtask

  task automatic t_thermal();
    @(negedge clk) tsd_act = 1'b1;
    edges(2);
    chk("R10", "run_en before thermal lands", run_en, 1'b1);
    edges(1);
    chk("R10", "thermal stops run", run_en, 1'b0);
    chk("R10", "thermal pg", pwr_good, 1'b0);
    edges(10);
    chk("R10", "thermal held off", run_en, 1'b0);
    @(negedge clk) tsd_act = 1'b0;
    edges(3);
    chk("R10", "restart run_en", run_en, 1'b1);
    chk("R10", "restart ss_start", ss_start, 1'b1);
    chk("R10", "restart ss_done low", ss_done, 1'b0);
    edges(SS + PGD + 5);
    chk("R10", "running after restart", ss_done, 1'b1);
    chk("R10", "pg after restart", pwr_good, 1'b1);
  endtask

  task automatic t_standby();
    @(negedge clk) en_pin = 1'b0;
    edges(2);
    chk("R1", "run_en before standby lands", run_en, 1'b1);
    edges(1);
    chk("R1", "standby run_en", run_en, 1'b0);
    chk("R1", "standby ss_done", ss_done, 1'b0);
    chk("R1", "standby pwr_good", pwr_good, 1'b0);
    chk("R1", "standby fault", fault_latched, 1'b0);
  endtask

  initial begin
    t_reset();
    t_start_up();
    t_hysteresis();
    t_high_ilim();
    t_trip();
    t_clear_by_enable();
    t_start_up();
    t_trip();
    t_clear_by_supply();
    t_start_up();
    t_thermal();
    t_standby();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule